// File: doc/BRIEF.md
# Cache Tag Fill Port Controller

This block decides which returning cache line may write the primary cache tag array. It also keeps processor loads and stores off the tags while a fill owns them. Two kinds of fill arrive. A demand fill answers a miss the processor is waiting on, and at most one of these is held at a time. A prefetch fill comes from an earlier prefetch and waits in a short first-in first-out queue. When the tags become free, the block picks a held demand fill before any queued prefetch. It then grants the tag port to that fill for a fixed run of cycles, and nothing can cut that run short.

For every fill, the block marks the first owned cycle with a start pulse and presents the line address. It also says whether the fill came from a demand or from a prefetch. A secondary cache write strobe fires in the last owned cycle, so each line lands in both cache levels. In any cycle where the tags are owned and the processor requests a tag access, the stall output is high in that same cycle.

Top module: `tag_fill_port`

## Requirements
- R1: While reset is high and in the first cycle after it, `tag_busy`, `fill_start`, `l2_wr` and `cpu_stall` are 0, and no fill is pending.
- R2: Every fill holds `tag_busy` high for exactly FILL_CYC consecutive cycles (default 4). `fill_start` is high in the first of these cycles only, and `fill_line` stays constant across all of them.
- R3: `cpu_stall` is high in exactly the cycles where `tag_busy` and `cpu_req` are both high, in the same cycle, with no register delay.
- R4: When the tags become free and both a demand fill and queued prefetch fills are pending, the demand fill starts first. `fill_is_pf` is 0 for a demand fill and 1 for a prefetch fill.
- R5: A demand fill that arrives while a prefetch fill owns the tags waits for all FILL_CYC cycles of that fill to finish.
- R6: When another fill is pending, it starts in the cycle right after the last owned cycle of the current fill, so `tag_busy` never drops between the two.
- R7: Prefetch fills are granted in the order in which they were accepted.
- R8: The prefetch queue holds PF_DEPTH lines (default 4). A prefetch request sampled while the queue is full is dropped and never granted.
- R9: One demand fill can be held. A demand request sampled while one is already held, including in the cycle where the held one starts, is ignored and never granted.
- R10: `l2_wr` is high only in the last owned cycle of each fill, with `fill_line` giving that fill's address.
- R11: A request sampled at a clock edge while the tags are idle produces `fill_start` in the cycle after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dmd_req | input | 1 | A demand-miss line has returned |
| dmd_line | input | LINE_W | Line address of the demand fill |
| pf_req | input | 1 | A prefetched line has returned |
| pf_line | input | LINE_W | Line address of the prefetch fill |
| cpu_req | input | 1 | Processor load or store wants the tags this cycle |
| fill_start | output | 1 | First cycle of a granted fill |
| fill_line | output | LINE_W | Line address of the fill that owns the tags |
| fill_is_pf | output | 1 | The owning fill came from a prefetch |
| l2_wr | output | 1 | Secondary cache write strobe, in the final fill cycle |
| tag_busy | output | 1 | A fill owns the tag array |
| cpu_stall | output | 1 | The processor access is held off this cycle |

## Verification
If the fill counter is corrupted, the length of the `tag_busy` window changes and `l2_wr` moves within that window. That shows up at the ports within FILL_CYC cycles of the start pulse. If the queue pointers or the demand slot hold wrong values, the wrong line address or source flag appears at the next `fill_start`, or a grant goes missing or is duplicated. The bench therefore checks every cycle against a behavioural model, and the directed sequences make sure each ordering and drop case produces a grant that can be seen.

// File: rtl/tfp_pkg.sv
package tfp_pkg;
  // Origin of the fill currently owning the tag array
  typedef enum logic {
    SRC_DEMAND   = 1'b0,
    SRC_PREFETCH = 1'b1
  } fill_src_e;
endpackage

// File: rtl/tfp_pf_queue.sv
// Circular first-in first-out store for prefetched line addresses.
// The storage array has no reset so that it maps onto RAM resources.
module tfp_pf_queue #(
  parameter int LINE_W = 26,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              pop_i,
  output logic [LINE_W-1:0] head_o,
  output logic              empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [LINE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic              full, do_push, do_pop;

  assign full    = (count == CNT_FULL);
  assign empty_o = (count == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= line_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/tfp_fill_timer.sv
// Counts the owned cycles of one fill, from FILL_CYC down to 1.
module tfp_fill_timer #(
  parameter int FILL_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic last_o,
  output logic free_o
);
  localparam int CNT_W = $clog2(FILL_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(FILL_CYC);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (start_i)   cnt <= CNT_LOAD;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);
  assign last_o = (cnt == CNT_W'(1));
  // Free at the next edge: either idle now or in the final owned cycle
  assign free_o = (cnt <= CNT_W'(1));
endmodule

// File: rtl/tfp_arbiter.sv
// Fixed-priority choice of the next fill: demand before prefetch.
module tfp_arbiter (
  input  logic free_i,
  input  logic dmd_pend_i,
  input  logic q_empty_i,
  output logic start_o,
  output logic take_dmd_o,
  output logic take_pf_o
);
  always_comb begin
    take_dmd_o = free_i && dmd_pend_i;
    take_pf_o  = free_i && !dmd_pend_i && !q_empty_i;
    start_o    = take_dmd_o || take_pf_o;
  end
endmodule

// File: rtl/tag_fill_port.sv
module tag_fill_port #(
  parameter int LINE_W   = 26,
  parameter int PF_DEPTH = 4,
  parameter int FILL_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dmd_req,
  input  logic [LINE_W-1:0] dmd_line,
  input  logic              pf_req,
  input  logic [LINE_W-1:0] pf_line,
  input  logic              cpu_req,
  output logic              fill_start,
  output logic [LINE_W-1:0] fill_line,
  output logic              fill_is_pf,
  output logic              l2_wr,
  output logic              tag_busy,
  output logic              cpu_stall
);
  import tfp_pkg::*;

  logic              dmd_pend_q;
  logic [LINE_W-1:0] dmd_line_q;
  logic [LINE_W-1:0] q_head;
  logic              q_empty;
  logic              t_busy, t_last, t_free;
  logic              arb_start, arb_dmd, arb_pf;
  fill_src_e         src_q;

  tfp_pf_queue #(.LINE_W(LINE_W), .DEPTH(PF_DEPTH)) u_queue (
    .clk     (clk),
    .rst     (rst),
    .push_i  (pf_req),
    .line_i  (pf_line),
    .pop_i   (arb_pf),
    .head_o  (q_head),
    .empty_o (q_empty)
  );

  tfp_arbiter u_arb (
    .free_i     (t_free),
    .dmd_pend_i (dmd_pend_q),
    .q_empty_i  (q_empty),
    .start_o    (arb_start),
    .take_dmd_o (arb_dmd),
    .take_pf_o  (arb_pf)
  );

  tfp_fill_timer #(.FILL_CYC(FILL_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start_i (arb_start),
    .busy_o  (t_busy),
    .last_o  (t_last),
    .free_o  (t_free)
  );

  // Demand slot and granted-fill registers
  always_ff @(posedge clk) begin
    if (rst) begin
      dmd_pend_q <= 1'b0;
      dmd_line_q <= '0;
      fill_start <= 1'b0;
      fill_line  <= '0;
      src_q      <= SRC_DEMAND;
    end else begin
      fill_start <= arb_start;
      if (arb_start) begin
        fill_line <= arb_dmd ? dmd_line_q : q_head;
        src_q     <= arb_dmd ? SRC_DEMAND : SRC_PREFETCH;
      end
      if (!dmd_pend_q) begin
        if (dmd_req) begin
          dmd_pend_q <= 1'b1;
          dmd_line_q <= dmd_line;
        end
      end else if (arb_dmd) begin
        dmd_pend_q <= 1'b0;
      end
    end
  end

  assign fill_is_pf = (src_q == SRC_PREFETCH);
  assign tag_busy   = t_busy;
  assign l2_wr      = t_last;
  assign cpu_stall  = t_busy && cpu_req;
endmodule

// File: rtl/tag_fill_port_chk.sv
module tag_fill_port_chk #(
  parameter int LINE_W   = 26,
  parameter int FILL_CYC = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              fill_start,
  input logic [LINE_W-1:0] fill_line,
  input logic              fill_is_pf,
  input logic              l2_wr,
  input logic              tag_busy,
  input logic              cpu_req,
  input logic              cpu_stall,
  input logic              dmd_pend
);
  localparam int RUN_W = $clog2(FILL_CYC + 2);

  // Owned cycles of the current fill that precede the present cycle
  logic [RUN_W-1:0] run;
  always_ff @(posedge clk) begin
    if (rst)             run <= '0;
    else if (fill_start) run <= RUN_W'(1);
    else if (tag_busy)   run <= run + 1'b1;
    else                 run <= '0;
  end

  AST_START_OWNS: assert property (@(posedge clk) disable iff (rst)
    fill_start |-> tag_busy);                                            // R2
  AST_FILL_MAX: assert property (@(posedge clk) disable iff (rst)
    (tag_busy && !fill_start) |-> (run != '0 && run < RUN_W'(FILL_CYC))); // R2
  AST_FILL_MIN: assert property (@(posedge clk) disable iff (rst)
    (run != '0 && run < RUN_W'(FILL_CYC)) |-> (tag_busy && !fill_start)); // R2
  AST_LINE_HELD: assert property (@(posedge clk) disable iff (rst)
    (tag_busy && !fill_start) |-> $stable(fill_line));                   // R2
  AST_STALL_IDLE: assert property (@(posedge clk) disable iff (rst)
    !tag_busy |-> !cpu_stall);                                           // R3
  AST_STALL_OWNED: assert property (@(posedge clk) disable iff (rst)
    (tag_busy && cpu_req) |-> cpu_stall);                                // R3
  AST_DEMAND_FIRST: assert property (@(posedge clk) disable iff (rst)
    (fill_start && fill_is_pf) |-> !$past(dmd_pend));                    // R4
  AST_L2_LAST: assert property (@(posedge clk) disable iff (rst)
    l2_wr |=> (!tag_busy || fill_start));                                // R10
  AST_L2_OWNED: assert property (@(posedge clk) disable iff (rst)
    l2_wr |-> tag_busy);                                                 // R10
endmodule

bind tag_fill_port tag_fill_port_chk #(.LINE_W(LINE_W), .FILL_CYC(FILL_CYC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fill_start (fill_start),
  .fill_line  (fill_line),
  .fill_is_pf (fill_is_pf),
  .l2_wr      (l2_wr),
  .tag_busy   (tag_busy),
  .cpu_req    (cpu_req),
  .cpu_stall  (cpu_stall),
  .dmd_pend   (dmd_pend_q)
);

// File: tb/tb_tag_fill_port.sv
module tb_tag_fill_port;
  localparam int LW    = 26;
  localparam int DEPTH = 4;
  localparam int FC    = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dmd_req = 1'b0, pf_req = 1'b0, cpu_req = 1'b0;
  logic [LW-1:0] dmd_line = '0, pf_line = '0;
  logic fill_start, fill_is_pf, l2_wr, tag_busy, cpu_stall;
  logic [LW-1:0] fill_line;

  tag_fill_port #(.LINE_W(LW), .PF_DEPTH(DEPTH), .FILL_CYC(FC)) dut (
    .clk(clk), .rst(rst), .dmd_req(dmd_req), .dmd_line(dmd_line),
    .pf_req(pf_req), .pf_line(pf_line), .cpu_req(cpu_req),
    .fill_start(fill_start), .fill_line(fill_line), .fill_is_pf(fill_is_pf),
    .l2_wr(l2_wr), .tag_busy(tag_busy), .cpu_stall(cpu_stall));

  always #10 clk = ~clk;  // 50 MHz

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_cnt = 0;
  bit m_dv = 0, m_start = 0, m_pf = 0;
  logic [LW-1:0] m_dl = '0, m_line = '0;
  logic [LW-1:0] m_q[$];

  always @(posedge clk) begin
    bit old_dv;
    int old_sz;
    if (rst) begin
      m_cnt = 0; m_dv = 0; m_start = 0; m_pf = 0; m_q.delete();
    end else begin
      old_dv = m_dv;
      old_sz = m_q.size();
      m_start = 0;
      if (m_cnt <= 1 && (m_dv || m_q.size() > 0)) begin
        m_start = 1;
        m_cnt = FC;
        if (m_dv) begin m_line = m_dl; m_pf = 0; m_dv = 0; end
        else begin m_line = m_q.pop_front(); m_pf = 1; end
      end else if (m_cnt > 0) begin
        m_cnt--;
      end
      if (dmd_req && !old_dv) begin m_dv = 1; m_dl = dmd_line; end
      if (pf_req && old_sz < DEPTH) m_q.push_back(pf_line);
    end
  end

  // Grant log and per-cycle comparison
  logic [LW-1:0] g_lines[$];
  bit g_pf[$];

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(tag_busy == (m_cnt != 0), "R2 busy", tag_busy, m_cnt != 0);
      chk(fill_start == m_start, "R6 fill_start", fill_start, m_start);
      chk(l2_wr == (m_cnt == 1), "R10 l2_wr", l2_wr, m_cnt == 1);
      chk(cpu_stall == ((m_cnt != 0) && cpu_req), "R3 stall", cpu_stall, (m_cnt != 0) && cpu_req);
      if (m_cnt != 0) begin
        chk(fill_line == m_line, "R7 fill_line", fill_line, m_line);
        chk(fill_is_pf == m_pf, "R4 fill_is_pf", fill_is_pf, m_pf);
      end
      if (fill_start) begin
        g_lines.push_back(fill_line);
        g_pf.push_back(fill_is_pf);
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic chk_grants(input string req, input logic [LW-1:0] exp[$]);
    chk(g_lines.size() == exp.size(), req, g_lines.size(), exp.size());
    for (int i = 0; i < exp.size() && i < g_lines.size(); i++)
      chk(g_lines[i] == exp[i], req, g_lines[i], exp[i]);
    g_lines.delete();
    g_pf.delete();
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [LW-1:0] exp[$];
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk(!tag_busy && !fill_start && !l2_wr && !cpu_stall, "R1 reset",
        {tag_busy, fill_start, l2_wr, cpu_stall}, 0);
    #1 rst = 1'b0;
    cpu_req = 1'b1;
    step();
    chk(!tag_busy && !fill_start && !cpu_stall, "R1 after reset",
        {tag_busy, fill_start, cpu_stall}, 0);

    // R11: single demand latency
    dmd_req = 1'b1; dmd_line = 26'h0A0;
    step();
    dmd_req = 1'b0;
    chk(fill_start == 1'b0, "R11 not yet", fill_start, 0);
    step();
    chk(fill_start == 1'b1 && fill_is_pf == 1'b0, "R11 start", fill_start, 1);
    chk(cpu_stall == 1'b1, "R3 stall in fill", cpu_stall, 1);
    idle(8);
    exp = '{26'h0A0};
    chk_grants("R11 grants", exp);

    // R4/R5: prefetches queued, demand arrives during a prefetch fill
    for (int i = 1; i <= 3; i++) begin
      pf_req = 1'b1; pf_line = LW'(26'h100 + i);
      if (i == 3) begin dmd_req = 1'b1; dmd_line = 26'h0D0; end
      step();
      dmd_req = 1'b0;
    end
    pf_req = 1'b0;
    idle(25);
    exp = '{26'h101, 26'h0D0, 26'h102, 26'h103};
    chk_grants("R4 R5 order", exp);

    // R8: queue overflow while a demand fill owns the tags
    dmd_req = 1'b1; dmd_line = 26'h0E0;
    for (int i = 1; i <= 6; i++) begin
      pf_req = 1'b1; pf_line = LW'(26'h200 + i);
      step();
      dmd_req = 1'b0;
    end
    pf_req = 1'b0;
    idle(30);
    exp = '{26'h0E0, 26'h201, 26'h202, 26'h203, 26'h204};
    chk_grants("R8 drop when full", exp);

    // R9: second demand while one is held is ignored
    dmd_req = 1'b1; dmd_line = 26'h0F1;
    step();
    dmd_line = 26'h0F2;
    step();
    dmd_req = 1'b0;
    idle(12);
    exp = '{26'h0F1};
    chk_grants("R9 single slot", exp);

    // Mixed traffic compared against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      dmd_req  = ($urandom_range(0, 9) == 0);
      dmd_line = LW'($urandom);
      pf_req   = ($urandom_range(0, 3) == 0);
      pf_line  = LW'($urandom);
      cpu_req  = $urandom_range(0, 1);
      step();
    end
    dmd_req = 1'b0; pf_req = 1'b0;
    idle(40);
    chk(!tag_busy, "R6 drained", tag_busy, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule